// File: doc/BRIEF.md
# NOR Flash Command Sequence Interpreter

This block watches the write side of a parallel NOR flash port and turns multi-cycle command sequences into operating modes and start requests. Each clock cycle with the write strobe high carries a word address and the low data byte. Two unlock writes (`555h`/`AAh`, then `2AAh`/`55h`) followed by a command byte at `555h` select the function. The block then either changes the mode or raises a one-cycle start pulse toward a separate program/erase engine. The pulse carries the latched target address and data.

The modes can stack. An ID-readout mode can have a query mode on top of it, so leaving the query mode takes one reset and leaving the ID-readout mode takes a second. A fast-program mode stays in place through ordinary resets and has its own two-write exit. An extra-block mode redirects any access that falls in the boot block to a separate 32K-word block.

On the read side, the block tells the datapath where the word on the bus must come from: the array, an ID code, a protection flag, the query table, or status. While the engine reports busy, every write is dropped and reads are steered to status.

Top module: `nor_cmd_interp`

## Requirements
- R1: After reset, `mode_o` is 0 (read array) and `rd_sel` is 0 (array). No start pulse or `err_clr` is raised.
- R2: Unlock cycles are `555h`/`AAh` then `2AAh`/`55h`, compared on the low 11 address bits. A write that does not match the next step of a multi-write sequence discards the partial sequence. The mode stays as it was and no start pulse follows.
- R3: `AAh`,`55h`,`90h` enters ID-readout mode (`mode_o`=1). With `rd_addr[1:0]`=00, `rd_sel`=1 and `rd_word`=0020h. With 01, `rd_sel`=1 and `rd_word`=22C7h. With 10, `rd_sel`=2 and `rd_word`=0001h if `prot_map` bit `rd_addr[21:15]` is set, else 0000h. In this mode every write other than `F0h` or `98h`@`55h` is ignored.
- R4: A single write of `98h` at `55h`, from read array or ID-readout, enters query mode (`mode_o`=2, `rd_sel`=3). `F0h` leaves it to the mode it was entered from.
- R5: `AAh`,`55h`,`A0h`, then one write at the target location raises `prog_start` for one cycle, in the cycle after that write. `op_addr`/`op_data` carry that write's address and data.
- R6: `AAh`,`55h`,`20h` enters fast-program mode (`mode_o`=3). In it, `A0h` then a target write raises `prog_start`. `90h` then `00h` returns to read array. `F0h` has no effect.
- R7: Reset is either one write of `F0h` or `AAh`,`55h`,`F0h`. It gives read array (or the mode below a stacked one) and a one-cycle `err_clr` in the next cycle.
- R8: `AAh`,`55h`,`80h`,`AAh`,`55h` followed by `10h`@`555h` raises `erase_start` with `erase_chip`=1. Followed instead by `30h` at any address, it raises `erase_start` with `erase_chip`=0 and `op_addr` equal to that address.
- R9: `AAh`,`55h`,`88h` enters extra-block mode (`mode_o`=4). There, `rd_ext` is high for read addresses in the boot block (block 127 by default), and `op_ext` is high on starts aimed there. `AAh`,`55h`,`90h`,`00h` returns to read array.
- R10: While `busy_in` is high, writes are ignored (no mode change, no pulse) and `rd_sel` is 4 (status).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 22 | Word address of the write |
| wr_data | input | 8 | Low data byte of the write |
| busy_in | input | 1 | Program/erase engine busy |
| rd_addr | input | 22 | Word address of the current read |
| prot_map | input | 128 | Per-block protection flags |
| mode_o | output | 3 | Active mode: 0 read, 1 ID, 2 query, 3 fast-program, 4 extra-block |
| rd_sel | output | 3 | Read source: 0 array, 1 ID, 2 protection, 3 query, 4 status |
| rd_word | output | 16 | ID or protection word when `rd_sel` is 1 or 2 |
| rd_ext | output | 1 | Read is redirected to the extra block |
| prog_start | output | 1 | One-cycle program request |
| erase_start | output | 1 | One-cycle erase request |
| erase_chip | output | 1 | Erase request covers the whole array |
| op_addr | output | 22 | Target address of the request |
| op_data | output | 8 | Program data |
| op_ext | output | 1 | Request aims at the extra block |
| err_clr | output | 1 | One-cycle request to clear status error |

## Verification
The bench corrupts each position of the program and erase sequences. A design that keeps a half-finished sequence would then fire a start pulse on the trailing writes, and the scoreboard would see a request it never queued. It walks the stacked exit from query mode through ID-readout to read array; a flat mode register would drop straight to read array after one reset. It sends a plain reset inside fast-program mode, which must survive it, and it repeats commands with the engine busy, where a design that skipped the gate would change mode or launch work.

// File: rtl/nor_ci_pkg.sv
package nor_ci_pkg;
   typedef enum logic [2:0] {
      M_READ = 3'd0,
      M_AUTO = 3'd1,
      M_CFI  = 3'd2,
      M_BYP  = 3'd3,
      M_EXT  = 3'd4
   } mode_e;

   typedef enum logic [2:0] {
      RS_ARRAY = 3'd0,
      RS_ID    = 3'd1,
      RS_PROT  = 3'd2,
      RS_CFI   = 3'd3,
      RS_STAT  = 3'd4
   } rsel_e;

   typedef enum logic [3:0] {
      Q_IDLE, Q_U1, Q_U2, Q_PGM, Q_E1, Q_E2, Q_E3, Q_XEXIT, Q_BPGM, Q_BRST
   } seq_e;

   localparam logic [7:0] CB_UNLK1 = 8'hAA;
   localparam logic [7:0] CB_UNLK2 = 8'h55;
   localparam logic [7:0] CB_AUTO  = 8'h90;
   localparam logic [7:0] CB_CFI   = 8'h98;
   localparam logic [7:0] CB_BYP   = 8'h20;
   localparam logic [7:0] CB_PGM   = 8'hA0;
   localparam logic [7:0] CB_ERS   = 8'h80;
   localparam logic [7:0] CB_CHIP  = 8'h10;
   localparam logic [7:0] CB_BLK   = 8'h30;
   localparam logic [7:0] CB_RST   = 8'hF0;
   localparam logic [7:0] CB_EXTIN = 8'h88;
   localparam logic [7:0] CB_ZERO  = 8'h00;
endpackage

// File: rtl/nor_ci_boot.sv
module nor_ci_boot #(
   parameter int ADDR_W    = 22,
   parameter int BLK_LSB   = 15,
   parameter bit BOOT_HIGH = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   if (BOOT_HIGH) begin : g_high
      assign hit = &addr[ADDR_W-1:BLK_LSB];
   end else begin : g_low
      assign hit = ~|addr[ADDR_W-1:BLK_LSB];
   end
endmodule

// File: rtl/nor_ci_seq.sv
module nor_ci_seq
   import nor_ci_pkg::*;
#(
   parameter int ADDR_W = 22,
   parameter int UNLK_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              busy_in,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              wr_boot,
   output mode_e             mode,
   output logic              prog_start,
   output logic              erase_start,
   output logic              erase_chip,
   output logic [ADDR_W-1:0] op_addr,
   output logic [7:0]        op_data,
   output logic              op_ext,
   output logic              err_clr
);
   localparam logic [UNLK_W-1:0] A_CMD = UNLK_W'('h555);
   localparam logic [UNLK_W-1:0] A_ALT = UNLK_W'('h2AA);
   localparam logic [UNLK_W-1:0] A_QRY = UNLK_W'('h055);

   mode_e base_q;
   logic  auto_q, cfi_q;
   seq_e  seq_q;
   logic  go, at_cmd, at_alt, at_qry, ext_tgt;

   always_comb begin
      go      = wr_en && !busy_in;
      at_cmd  = wr_addr[UNLK_W-1:0] == A_CMD;
      at_alt  = wr_addr[UNLK_W-1:0] == A_ALT;
      at_qry  = wr_addr[UNLK_W-1:0] == A_QRY;
      ext_tgt = (base_q == M_EXT) && wr_boot;
      if (cfi_q)       mode = M_CFI;
      else if (auto_q) mode = M_AUTO;
      else             mode = base_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q      <= M_READ;
         auto_q      <= 1'b0;
         cfi_q       <= 1'b0;
         seq_q       <= Q_IDLE;
         prog_start  <= 1'b0;
         erase_start <= 1'b0;
         erase_chip  <= 1'b0;
         op_addr     <= '0;
         op_data     <= '0;
         op_ext      <= 1'b0;
         err_clr     <= 1'b0;
      end else begin
         prog_start  <= 1'b0;
         erase_start <= 1'b0;
         err_clr     <= 1'b0;
         if (go) begin
            if (cfi_q) begin
               if (wr_data == CB_RST) begin
                  cfi_q   <= 1'b0;
                  err_clr <= 1'b1;
               end
            end else if (auto_q) begin
               if (wr_data == CB_RST) begin
                  auto_q  <= 1'b0;
                  err_clr <= 1'b1;
               end else if (at_qry && wr_data == CB_CFI) begin
                  cfi_q <= 1'b1;
               end
            end else if (base_q == M_BYP) begin
               case (seq_q)
                  Q_BPGM: begin
                     prog_start <= 1'b1;
                     op_addr    <= wr_addr;
                     op_data    <= wr_data;
                     op_ext     <= 1'b0;
                     seq_q      <= Q_IDLE;
                  end
                  Q_BRST: begin
                     if (wr_data == CB_ZERO) base_q <= M_READ;
                     seq_q <= Q_IDLE;
                  end
                  default: begin
                     if (wr_data == CB_PGM)       seq_q <= Q_BPGM;
                     else if (wr_data == CB_AUTO) seq_q <= Q_BRST;
                     else                         seq_q <= Q_IDLE;
                  end
               endcase
            end else begin
               seq_q <= Q_IDLE;
               case (seq_q)
                  Q_IDLE: begin
                     if (wr_data == CB_RST) err_clr <= 1'b1;
                     else if (at_qry && wr_data == CB_CFI) cfi_q <= 1'b1;
                     else if (at_cmd && wr_data == CB_UNLK1) seq_q <= Q_U1;
                  end
                  Q_U1: if (at_alt && wr_data == CB_UNLK2) seq_q <= Q_U2;
                  Q_U2: begin
                     if (at_cmd) begin
                        case (wr_data)
                           CB_AUTO: begin
                              if (base_q == M_EXT) seq_q <= Q_XEXIT;
                              else auto_q <= 1'b1;
                           end
                           CB_BYP:   if (base_q == M_READ) base_q <= M_BYP;
                           CB_EXTIN: if (base_q == M_READ) base_q <= M_EXT;
                           CB_PGM:   seq_q <= Q_PGM;
                           CB_ERS:   seq_q <= Q_E1;
                           CB_RST:   err_clr <= 1'b1;
                           default:  seq_q <= Q_IDLE;
                        endcase
                     end
                  end
                  Q_PGM: begin
                     prog_start <= 1'b1;
                     op_addr    <= wr_addr;
                     op_data    <= wr_data;
                     op_ext     <= ext_tgt;
                  end
                  Q_E1: if (at_cmd && wr_data == CB_UNLK1) seq_q <= Q_E2;
                  Q_E2: if (at_alt && wr_data == CB_UNLK2) seq_q <= Q_E3;
                  Q_E3: begin
                     if (at_cmd && wr_data == CB_CHIP) begin
                        erase_start <= 1'b1;
                        erase_chip  <= 1'b1;
                        op_addr     <= wr_addr;
                        op_ext      <= 1'b0;
                     end else if (wr_data == CB_BLK) begin
                        erase_start <= 1'b1;
                        erase_chip  <= 1'b0;
                        op_addr     <= wr_addr;
                        op_ext      <= ext_tgt;
                     end
                  end
                  Q_XEXIT: if (wr_data == CB_ZERO) base_q <= M_READ;
                  default: seq_q <= Q_IDLE;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/nor_ci_rdmux.sv
module nor_ci_rdmux
   import nor_ci_pkg::*;
#(
   parameter int          ADDR_W  = 22,
   parameter int          BLK_LSB = 15,
   parameter logic [15:0] MFR_ID  = 16'h0020,
   parameter logic [15:0] DEV_ID  = 16'h22C7
) (
   input  mode_e                             mode,
   input  logic                              busy_in,
   input  logic [ADDR_W-1:0]                 rd_addr,
   input  logic [(1<<(ADDR_W-BLK_LSB))-1:0]  prot_map,
   input  logic                              rd_boot,
   output rsel_e                             rd_sel,
   output logic [15:0]                       rd_word,
   output logic                              rd_ext
);
   localparam int BLK_W = ADDR_W - BLK_LSB;

   logic [BLK_W-1:0] blk_idx;
   logic             unused_low;

   assign blk_idx    = rd_addr[ADDR_W-1:BLK_LSB];
   assign unused_low = ^rd_addr[BLK_LSB-1:2];
   assign rd_ext     = (mode == M_EXT) && rd_boot;

   always_comb begin
      rd_sel  = RS_ARRAY;
      rd_word = 16'h0000;
      if (busy_in) begin
         rd_sel = RS_STAT;
      end else if (mode == M_CFI) begin
         rd_sel = RS_CFI;
      end else if (mode == M_AUTO) begin
         case (rd_addr[1:0])
            2'b00: begin rd_sel = RS_ID;   rd_word = MFR_ID; end
            2'b01: begin rd_sel = RS_ID;   rd_word = DEV_ID; end
            2'b10: begin rd_sel = RS_PROT; rd_word = {15'd0, prot_map[blk_idx]}; end
            default: rd_sel = RS_ID;
         endcase
      end
   end
endmodule

// File: rtl/nor_cmd_interp.sv
module nor_cmd_interp
   import nor_ci_pkg::*;
#(
   parameter int          ADDR_W    = 22,
   parameter int          BLK_LSB   = 15,
   parameter int          UNLK_W    = 11,
   parameter bit          BOOT_HIGH = 1'b1,
   parameter logic [15:0] MFR_ID    = 16'h0020,
   parameter logic [15:0] DEV_ID    = 16'h22C7
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [7:0]                       wr_data,
   input  logic                             busy_in,
   input  logic [ADDR_W-1:0]                rd_addr,
   input  logic [(1<<(ADDR_W-BLK_LSB))-1:0] prot_map,
   output logic [2:0]                       mode_o,
   output logic [2:0]                       rd_sel,
   output logic [15:0]                      rd_word,
   output logic                             rd_ext,
   output logic                             prog_start,
   output logic                             erase_start,
   output logic                             erase_chip,
   output logic [ADDR_W-1:0]                op_addr,
   output logic [7:0]                       op_data,
   output logic                             op_ext,
   output logic                             err_clr
);
   if (ADDR_W <= BLK_LSB) begin : g_bad_blk
      $error("ADDR_W must exceed BLK_LSB");
   end
   if (ADDR_W < UNLK_W || UNLK_W < 10) begin : g_bad_unlk
      $error("UNLK_W must lie between 10 and ADDR_W");
   end

   mode_e mode;
   rsel_e sel;
   logic  wr_boot, rd_boot;

   nor_ci_boot #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .BOOT_HIGH(BOOT_HIGH))
      u_boot_wr (.addr(wr_addr), .hit(wr_boot));
   nor_ci_boot #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .BOOT_HIGH(BOOT_HIGH))
      u_boot_rd (.addr(rd_addr), .hit(rd_boot));

   nor_ci_seq #(.ADDR_W(ADDR_W), .UNLK_W(UNLK_W)) u_seq (
      .clk, .rst_n, .wr_en, .busy_in, .wr_addr, .wr_data, .wr_boot,
      .mode, .prog_start, .erase_start, .erase_chip, .op_addr, .op_data,
      .op_ext, .err_clr
   );

   nor_ci_rdmux #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
      .mode, .busy_in, .rd_addr, .prot_map, .rd_boot,
      .rd_sel(sel), .rd_word, .rd_ext
   );

   assign mode_o = mode;
   assign rd_sel = sel;
endmodule

// File: rtl/nor_cmd_interp_chk.sv
module nor_cmd_interp_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic       busy_in,
   input logic [2:0] mode_o,
   input logic [2:0] rd_sel,
   input logic       prog_start,
   input logic       erase_start,
   input logic       erase_chip,
   input logic       err_clr
);
   a_r10_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy_in) |=> (mode_o == $past(mode_o)) && !prog_start && !erase_start && !err_clr);

   a_r10_status_sel: assert property (@(posedge clk) disable iff (!rst_n)
      busy_in |-> rd_sel == 3'd4);

   a_r6_reset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd3 && wr_en && !busy_in && wr_data == 8'hF0) |=> mode_o == 3'd3);

   a_r3_id_only_in_auto: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == 3'd1 || rd_sel == 3'd2) |-> mode_o == 3'd1);

   a_r5_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_start, erase_start, err_clr}));

   a_r5_start_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_start || erase_start) |-> $past(wr_en && !busy_in));

   a_r8_chip_code: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_start && erase_chip) |-> $past(wr_data) == 8'h10);
endmodule

bind nor_cmd_interp nor_cmd_interp_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .busy_in(busy_in),
   .mode_o(mode_o), .rd_sel(rd_sel), .prog_start(prog_start),
   .erase_start(erase_start), .erase_chip(erase_chip), .err_clr(err_clr)
);

// File: tb/nor_cmd_interp_bench.sv
module nor_cmd_interp_bench;
   logic         clk = 1'b0;
   logic         rst_n, wr_en, busy_in;
   logic [21:0]  wr_addr, rd_addr;
   logic [7:0]   wr_data;
   logic [127:0] prot_map;
   logic [2:0]   mode_o, rd_sel;
   logic [15:0]  rd_word;
   logic         rd_ext, prog_start, erase_start, erase_chip, op_ext, err_clr;
   logic [21:0]  op_addr;
   logic [7:0]   op_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct packed {
      logic        is_erase;
      logic        chip;
      logic [21:0] addr;
      logic [7:0]  data;
      logic        ext;
   } req_t;
   req_t  exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   nor_cmd_interp u_nor_cmd_interp (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .busy_in, .rd_addr, .prot_map,
      .mode_o, .rd_sel, .rd_word, .rd_ext, .prog_start, .erase_start, .erase_chip,
      .op_addr, .op_data, .op_ext, .err_clr
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic wr(input logic [21:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic unl();
      wr(22'h555, 8'hAA);
      wr(22'h2AA, 8'h55);
   endtask

   task automatic expect_req(input string tag, input logic e, input logic c,
                             input logic [21:0] a, input logic [7:0] d, input logic x);
      exp_q.push_back('{is_erase: e, chip: c, addr: a, data: d, ext: x});
      tag_q.push_back(tag);
   endtask

   task automatic rd_chk(input string tag, input logic [21:0] a, input logic [2:0] sel,
                         input logic [15:0] word);
      rd_addr = a;
      #1;
      chk(tag, {29'd0, rd_sel}, {29'd0, sel});
      chk(tag, {16'd0, rd_word}, {16'd0, word});
   endtask

   // Scoreboard monitor: every start pulse must match the oldest queued request.
   always @(negedge clk) begin
      if (rst_n && (prog_start || erase_start)) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R2/R10 unexpected start actual=%0h expected=none", {prog_start, erase_start});
         end else begin
            req_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (erase_start !== e.is_erase || (e.is_erase && erase_chip !== e.chip)
                || (!(e.is_erase && e.chip) && op_addr !== e.addr)
                || (!e.is_erase && op_data !== e.data) || op_ext !== e.ext) begin
               n_fail++;
               $display("FAIL %s actual=%0h expected=%0h", t,
                        {erase_start, erase_chip, op_addr, op_data, op_ext},
                        {e.is_erase, e.chip, e.addr, e.data, e.ext});
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         summary();
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; busy_in = 1'b0;
      rd_addr = '0; prot_map = '0; prot_map[5] = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 mode", {29'd0, mode_o}, 0);
      rd_chk("R1 rd_sel", 22'h0, 3'd0, 16'h0);
      chk("R1 err_clr", {31'd0, err_clr}, 0);

      // R3 ID readout
      unl(); wr(22'h555, 8'h90);
      chk("R3 mode", {29'd0, mode_o}, 1);
      rd_chk("R3 mfr", 22'h0, 3'd1, 16'h0020);
      rd_chk("R3 dev", 22'h1, 3'd1, 16'h22C7);
      rd_chk("R3 prot set", {7'd5, 15'h2}, 3'd2, 16'h0001);
      rd_chk("R3 prot clr", {7'd6, 15'h2}, 3'd2, 16'h0000);
      unl(); wr(22'h555, 8'hA0); wr(22'h000100, 8'h5A);
      chk("R3 ignores program", {29'd0, mode_o}, 1);

      // R4 stacked query exit
      wr(22'h055, 8'h98);
      chk("R4 query from ID", {29'd0, mode_o}, 2);
      rd_chk("R4 rd_sel", 22'h0, 3'd3, 16'h0);
      wr(22'h0, 8'hF0);
      chk("R4 back to ID", {29'd0, mode_o}, 1);
      wr(22'h0, 8'hF0);
      chk("R7 second reset", {29'd0, mode_o}, 0);
      wr(22'h055, 8'h98);
      chk("R4 query from read", {29'd0, mode_o}, 2);
      wr(22'h0, 8'hF0);
      chk("R4 back to read", {29'd0, mode_o}, 0);

      // R5 program
      expect_req("R5 program", 1'b0, 1'b0, 22'h012345, 8'hC3, 1'b0);
      unl(); wr(22'h555, 8'hA0); wr(22'h012345, 8'hC3);
      chk("R5 mode after", {29'd0, mode_o}, 0);

      // R2 corrupt each position of the program sequence
      for (int p = 0; p < 3; p++) begin
         logic [21:0] a[4];
         logic [7:0]  d[4];
         a = '{22'h555, 22'h2AA, 22'h555, 22'h001234};
         d = '{8'hAA, 8'h55, 8'hA0, 8'h5A};
         d[p] = 8'h11;
         for (int k = 0; k < 4; k++) wr(a[k], d[k]);
         chk("R2 program broken", {29'd0, mode_o}, 0);
      end

      // R2 corrupt each position of the erase sequence
      for (int p = 0; p < 6; p++) begin
         logic [21:0] a[6];
         logic [7:0]  d[6];
         a = '{22'h555, 22'h2AA, 22'h555, 22'h555, 22'h2AA, 22'h555};
         d = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
         d[p] = 8'h11;
         for (int k = 0; k < 6; k++) wr(a[k], d[k]);
         chk("R2 erase broken", {29'd0, mode_o}, 0);
      end

      // R8 chip and block erase
      expect_req("R8 chip erase", 1'b1, 1'b1, 22'h0, 8'h0, 1'b0);
      unl(); wr(22'h555, 8'h80); unl(); wr(22'h555, 8'h10);
      expect_req("R8 block erase", 1'b1, 1'b0, 22'h0A8000, 8'h0, 1'b0);
      unl(); wr(22'h555, 8'h80); unl(); wr(22'h0A8000, 8'h30);

      // R7 reset forms
      wr(22'h0, 8'hF0);
      chk("R7 single-write err_clr", {31'd0, err_clr}, 1);
      @(negedge clk);
      chk("R7 err_clr one cycle", {31'd0, err_clr}, 0);
      unl(); wr(22'h555, 8'hF0);
      chk("R7 three-write err_clr", {31'd0, err_clr}, 1);

      // R6 fast-program mode
      unl(); wr(22'h555, 8'h20);
      chk("R6 enter", {29'd0, mode_o}, 3);
      wr(22'h0, 8'hF0);
      chk("R6 reset ignored", {29'd0, mode_o}, 3);
      expect_req("R6 short program", 1'b0, 1'b0, 22'h000321, 8'h3C, 1'b0);
      wr(22'h0, 8'hA0); wr(22'h000321, 8'h3C);
      chk("R6 still fast", {29'd0, mode_o}, 3);
      wr(22'h0, 8'h90); wr(22'h0, 8'h00);
      chk("R6 exit", {29'd0, mode_o}, 0);

      // R9 extra-block mode
      unl(); wr(22'h555, 8'h88);
      chk("R9 enter", {29'd0, mode_o}, 4);
      rd_addr = {7'h7F, 15'h0010}; #1;
      chk("R9 boot read redirected", {31'd0, rd_ext}, 1);
      rd_addr = 22'h000010; #1;
      chk("R9 other read direct", {31'd0, rd_ext}, 0);
      expect_req("R9 program redirected", 1'b0, 1'b0, {7'h7F, 15'h0005}, 8'h66, 1'b1);
      unl(); wr(22'h555, 8'hA0); wr({7'h7F, 15'h0005}, 8'h66);
      unl(); wr(22'h555, 8'h90); wr(22'h0, 8'h77);
      chk("R9 bad exit stays", {29'd0, mode_o}, 4);
      unl(); wr(22'h555, 8'h90); wr(22'h0, 8'h00);
      chk("R9 exit", {29'd0, mode_o}, 0);
      rd_addr = {7'h7F, 15'h0010}; #1;
      chk("R9 no redirect after exit", {31'd0, rd_ext}, 0);

      // R10 busy gate
      busy_in = 1'b1;
      rd_chk("R10 status sel", 22'h0, 3'd4, 16'h0);
      wr(22'h055, 8'h98);
      chk("R10 query ignored", {29'd0, mode_o}, 0);
      unl(); wr(22'h555, 8'hA0); wr(22'h000200, 8'h77);
      busy_in = 1'b0;
      chk("R10 mode unchanged", {29'd0, mode_o}, 0);
      rd_chk("R10 array after busy", 22'h0, 3'd0, 16'h0);

      repeat (3) @(negedge clk);
      chk("R5 R8 all requests seen", exp_q.size(), 0);
      done = 1'b1;
      summary();
   end
endmodule